// File: doc/BRIEF.md
# Interrupt Class Arbiter

This block decides which class of interrupt the processor core takes next. It keeps small last-in-first-out stacks of queued external interrupts, machine checks and I/O interrupts, with one I/O stack for each of eight subclasses. It also keeps two timer request flags, one for the clock comparator and one for the CPU timer. From these and from the enable bits of the current status word it presents one winning class, a 16-bit interruption code and a 32-bit data word. When the core acknowledges a presented interrupt, the block removes the delivered entry.

An exception that instruction execution has already latched, such as a program check or a supervisor call, reaches the block as a side input and ranks above every asynchronous class. The block keeps one summary pending bit for each source and drives a registered interrupt request to the core while any of these bits is set. Writing the old and new status words and saving registers are left to the core.

Top module: `irq_class_arbiter`

## Requirements
- R1: The presented class follows a fixed priority: a latched synchronous exception first (class code 1), then machine check (2), then external (3), then I/O (4). A class is presented only when it has work pending and its status-word enable (`psw_mchk_en`, `psw_ext_en`, `psw_io_en`) is high. Class code 0 with `sel_valid` low means nothing is presented.
- R2: Within the external class, a queued external entry wins and supplies its own code and parameter. If none is queued, a clock-comparator request is presented with code 0x1004. If neither applies, a CPU-timer request is presented with code 0x1005. Timer deliveries carry data 0.
- R3: Acknowledging a timer delivery clears only that timer's request flag. A new request arriving in the same cycle keeps the flag set.
- R4: I/O subclasses are scanned from 0 upward. A subclass qualifies only when bit i of `io_sub_mask` is set and its stack is not empty. The first qualifying subclass is presented with code equal to its subclass number and data equal to its top word.
- R5: An I/O entry in a masked-off subclass stays queued, and the request stays asserted. When the mask bit is later set, the entry is delivered.
- R6: While `crw_enable` is low, a machine check that would win priority is popped and discarded without being presented (`sel_valid` low in that cycle).
- R7: Every stack is last-in-first-out. An acknowledge pops the delivered entry. A push and a pop on the same stack in the same cycle replace the top entry.
- R8: A push onto a full stack, with no pop in that cycle, is discarded and sets that stack group's sticky overflow flag (`ext_ovf`, `io_ovf` or `mck_ovf`).
- R9: `irq_req` is high in the cycle after any queued entry or timer flag exists. It drops in the cycle after the last one is removed.
- R10: An acknowledge while `sel_valid` is low has no effect on any stack or flag.
- R11: After reset, every stack and flag is empty and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psw_mchk_en | input | 1 | Status-word machine-check enable |
| psw_ext_en | input | 1 | Status-word external enable |
| psw_io_en | input | 1 | Status-word I/O enable |
| io_sub_mask | input | 8 | Per-subclass I/O enable mask |
| crw_enable | input | 1 | Channel-report machine-check enable |
| exc_sync_valid | input | 1 | Latched program or supervisor-call exception |
| exc_sync_code | input | 16 | Code of the latched exception |
| tod_req | input | 1 | Clock-comparator request pulse |
| cpt_req | input | 1 | CPU-timer request pulse |
| ext_push | input | 1 | Queue an external interrupt |
| ext_push_code | input | 16 | External interruption code |
| ext_push_param | input | 32 | External parameter |
| io_push | input | 1 | Queue an I/O interrupt |
| io_push_sub | input | 3 | Target I/O subclass |
| io_push_word | input | 32 | I/O interruption word |
| mck_push | input | 1 | Queue a machine check |
| mck_push_info | input | 32 | Machine-check information |
| ack | input | 1 | Core takes the presented interrupt |
| sel_valid | output | 1 | A class is presented |
| sel_class | output | 3 | Presented class code |
| sel_code | output | 16 | Interruption code |
| sel_data | output | 32 | Entry data word |
| irq_req | output | 1 | Registered request to the core |
| ext_ovf | output | 1 | Sticky external-stack overflow |
| io_ovf | output | 1 | Sticky I/O-stack overflow |
| mck_ovf | output | 1 | Sticky machine-check-stack overflow |

## Verification
The selection outputs are decoded combinationally from registered stack and flag state. A push, pop, drop or timer change that is sampled at a rising edge therefore shows in the selection one edge later. Changes to the enables, the mask, `crw_enable` or the synchronous exception show in the same cycle. `irq_req` comes from the same edge as the state it summarises. The bench drives inputs shortly after each rising edge and samples every output at the falling edge. It compares them with a behavioural model that applies the same pops and pushes at the rising edge, so each expected value is taken in exactly the cycle its result is due.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [2:0] {
        CLS_NONE = 3'd0,
        CLS_SYNC = 3'd1,
        CLS_MCHK = 3'd2,
        CLS_EXT  = 3'd3,
        CLS_IO   = 3'd4
    } irq_class_e;

    localparam logic [15:0] CODE_CLKCMP = 16'h1004;
    localparam logic [15:0] CODE_CPUTMR = 16'h1005;

    typedef struct packed {
        logic mck;
        logic ext;
        logic io;
        logic tod;
        logic cpt;
    } pend_t;

    typedef struct packed {
        pend_t pend;
        logic  irq;
    } arb_state_t;

endpackage

// File: rtl/irq_lifo.sv
module irq_lifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               top,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic                       ovf
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem_q [DEPTH];
    logic [W-1:0]  mem_d [DEPTH];
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ovf_q, ovf_d;
    logic [CW-1:0] cm1;
    logic          full;

    assign cm1  = cnt_q - CW'(1);
    assign full = (cnt_q == CW'(DEPTH));

    always_comb begin
        mem_d = mem_q;
        cnt_d = cnt_q;
        ovf_d = ovf_q;
        if (pop && cnt_q != '0) begin
            if (push) mem_d[cm1[AW-1:0]] = din;
            else      cnt_d = cm1;
        end else if (push) begin
            if (full) begin
                ovf_d = 1'b1;
            end else begin
                mem_d[cnt_q[AW-1:0]] = din;
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            mem_q <= mem_d;
            cnt_q <= cnt_d;
            ovf_q <= ovf_d;
        end
    end

    assign top = (cnt_q == '0) ? '0 : mem_q[cm1[AW-1:0]];
    assign cnt = cnt_q;
    assign ovf = ovf_q;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R7
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/io_subclass_scan.sv
module io_subclass_scan #(
    parameter int NSUB = 8
) (
    input  logic [NSUB-1:0]         nonempty,
    input  logic [NSUB-1:0]         mask,
    output logic                    found,
    output logic [$clog2(NSUB)-1:0] idx
);
    localparam int SW = $clog2(NSUB);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NSUB - 1; i >= 0; i--) begin
            if (nonempty[i] && mask[i]) begin
                found = 1'b1;
                idx   = SW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_class_arbiter.sv
module irq_class_arbiter
    import irq_arb_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int NSUB   = 8,
    parameter int WORD_W = 32,
    parameter int CODE_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    psw_mchk_en,
    input  logic                    psw_ext_en,
    input  logic                    psw_io_en,
    input  logic [NSUB-1:0]         io_sub_mask,
    input  logic                    crw_enable,
    input  logic                    exc_sync_valid,
    input  logic [CODE_W-1:0]       exc_sync_code,
    input  logic                    tod_req,
    input  logic                    cpt_req,
    input  logic                    ext_push,
    input  logic [CODE_W-1:0]       ext_push_code,
    input  logic [WORD_W-1:0]       ext_push_param,
    input  logic                    io_push,
    input  logic [$clog2(NSUB)-1:0] io_push_sub,
    input  logic [WORD_W-1:0]       io_push_word,
    input  logic                    mck_push,
    input  logic [WORD_W-1:0]       mck_push_info,
    input  logic                    ack,
    output logic                    sel_valid,
    output logic [2:0]              sel_class,
    output logic [CODE_W-1:0]       sel_code,
    output logic [WORD_W-1:0]       sel_data,
    output logic                    irq_req,
    output logic                    ext_ovf,
    output logic                    io_ovf,
    output logic                    mck_ovf
);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int SW    = $clog2(NSUB);
    localparam int EXT_W = CODE_W + WORD_W;

    arb_state_t st_q, st_d;

    logic [EXT_W-1:0]  ext_top;
    logic [CW-1:0]     ext_cnt;
    logic [WORD_W-1:0] mck_top;
    logic [CW-1:0]     mck_cnt;
    logic [WORD_W-1:0] io_top [NSUB];
    logic [CW-1:0]     io_cnt [NSUB];
    logic [NSUB-1:0]   io_ovf_v, io_nonempty, io_remain;
    logic              io_found;
    logic [SW-1:0]     io_idx;

    irq_class_e        cls;
    logic [CODE_W-1:0] code;
    logic [WORD_W-1:0] data;
    logic              drop_mck, take, ext_pop, mck_pop, io_pop, tod_clr, cpt_clr;

    irq_lifo #(.W(EXT_W), .DEPTH(DEPTH)) u_ext_q (
        .clk(clk), .rst_n(rst_n), .push(ext_push), .pop(ext_pop),
        .din({ext_push_code, ext_push_param}), .top(ext_top),
        .cnt(ext_cnt), .ovf(ext_ovf)
    );

    irq_lifo #(.W(WORD_W), .DEPTH(DEPTH)) u_mck_q (
        .clk(clk), .rst_n(rst_n), .push(mck_push), .pop(mck_pop),
        .din(mck_push_info), .top(mck_top),
        .cnt(mck_cnt), .ovf(mck_ovf)
    );

    for (genvar g = 0; g < NSUB; g++) begin : g_io
        logic push_g, pop_g;
        assign push_g = io_push && (io_push_sub == SW'(g));
        assign pop_g  = io_pop && (io_idx == SW'(g));
        irq_lifo #(.W(WORD_W), .DEPTH(DEPTH)) u_q (
            .clk(clk), .rst_n(rst_n), .push(push_g), .pop(pop_g),
            .din(io_push_word), .top(io_top[g]),
            .cnt(io_cnt[g]), .ovf(io_ovf_v[g])
        );
        assign io_nonempty[g] = (io_cnt[g] != '0);
        assign io_remain[g]   = (io_idx == SW'(g)) ? (io_cnt[g] > CW'(1))
                                                   : io_nonempty[g];
    end

    assign io_ovf = |io_ovf_v;

    io_subclass_scan #(.NSUB(NSUB)) u_scan (
        .nonempty(io_nonempty), .mask(io_sub_mask),
        .found(io_found), .idx(io_idx)
    );

    // class selection from registered state
    always_comb begin
        cls      = CLS_NONE;
        code     = '0;
        data     = '0;
        drop_mck = 1'b0;
        if (exc_sync_valid) begin
            cls  = CLS_SYNC;
            code = exc_sync_code;
        end else if (psw_mchk_en && st_q.pend.mck) begin
            if (crw_enable) begin
                cls  = CLS_MCHK;
                data = mck_top;
            end else begin
                drop_mck = 1'b1;
            end
        end else if (psw_ext_en && (st_q.pend.ext || st_q.pend.tod || st_q.pend.cpt)) begin
            cls = CLS_EXT;
            if (st_q.pend.ext) begin
                code = ext_top[EXT_W-1:WORD_W];
                data = ext_top[WORD_W-1:0];
            end else if (st_q.pend.tod) begin
                code = CODE_CLKCMP;
            end else begin
                code = CODE_CPUTMR;
            end
        end else if (psw_io_en && io_found) begin
            cls  = CLS_IO;
            code = CODE_W'(io_idx);
            data = io_top[io_idx];
        end
    end

    // pops, flag clears and next state
    always_comb begin
        take    = ack && (cls != CLS_NONE);
        ext_pop = take && (cls == CLS_EXT) && st_q.pend.ext;
        tod_clr = take && (cls == CLS_EXT) && !st_q.pend.ext && st_q.pend.tod;
        cpt_clr = take && (cls == CLS_EXT) && !st_q.pend.ext && !st_q.pend.tod;
        mck_pop = (take && (cls == CLS_MCHK)) || drop_mck;
        io_pop  = take && (cls == CLS_IO);

        st_d = st_q;
        if (ext_push)                             st_d.pend.ext = 1'b1;
        else if (ext_pop && ext_cnt == CW'(1))    st_d.pend.ext = 1'b0;
        if (mck_push)                             st_d.pend.mck = 1'b1;
        else if (mck_pop && mck_cnt == CW'(1))    st_d.pend.mck = 1'b0;
        if (io_push)                              st_d.pend.io  = 1'b1;
        else if (io_pop)                          st_d.pend.io  = |io_remain;
        if (tod_req)                              st_d.pend.tod = 1'b1;
        else if (tod_clr)                         st_d.pend.tod = 1'b0;
        if (cpt_req)                              st_d.pend.cpt = 1'b1;
        else if (cpt_clr)                         st_d.pend.cpt = 1'b0;
        st_d.irq = |st_d.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_valid = (cls != CLS_NONE);
    assign sel_class = cls;
    assign sel_code  = code;
    assign sel_data  = data;
    assign irq_req   = st_q.irq;

    // R1
    mchk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_class == CLS_MCHK) |-> (psw_mchk_en && crw_enable && !exc_sync_valid));

    // R9
    req_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_class != CLS_SYNC) |-> irq_req);

    // R4
    io_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_class == CLS_IO) |-> (io_sub_mask[sel_code[SW-1:0]] && psw_io_en));

    // R6
    mck_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend.mck && psw_mchk_en && !crw_enable && !exc_sync_valid) |-> !sel_valid);

    // R3
    tod_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && sel_valid && sel_class == CLS_EXT && sel_code == CODE_CLKCMP
         && !st_q.pend.ext && !tod_req) |=> !st_q.pend.tod);

endmodule

// File: tb/irq_class_arbiter_test.sv
module irq_class_arbiter_test;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psw_mchk_en = 0, psw_ext_en = 0, psw_io_en = 0;
    logic [7:0]  io_sub_mask = 8'h00;
    logic        crw_enable = 0, exc_sync_valid = 0;
    logic [15:0] exc_sync_code = 16'h0;
    logic        tod_req = 0, cpt_req = 0;
    logic        ext_push = 0;
    logic [15:0] ext_push_code = 0;
    logic [31:0] ext_push_param = 0;
    logic        io_push = 0;
    logic [2:0]  io_push_sub = 0;
    logic [31:0] io_push_word = 0;
    logic        mck_push = 0;
    logic [31:0] mck_push_info = 0;
    logic        ack = 0;
    logic        sel_valid, irq_req, ext_ovf, io_ovf, mck_ovf;
    logic [2:0]  sel_class;
    logic [15:0] sel_code;
    logic [31:0] sel_data;

    always #10 clk = ~clk;

    irq_class_arbiter uut (
        .clk(clk), .rst_n(rst_n), .psw_mchk_en(psw_mchk_en), .psw_ext_en(psw_ext_en),
        .psw_io_en(psw_io_en), .io_sub_mask(io_sub_mask), .crw_enable(crw_enable),
        .exc_sync_valid(exc_sync_valid), .exc_sync_code(exc_sync_code),
        .tod_req(tod_req), .cpt_req(cpt_req), .ext_push(ext_push),
        .ext_push_code(ext_push_code), .ext_push_param(ext_push_param),
        .io_push(io_push), .io_push_sub(io_push_sub), .io_push_word(io_push_word),
        .mck_push(mck_push), .mck_push_info(mck_push_info), .ack(ack),
        .sel_valid(sel_valid), .sel_class(sel_class), .sel_code(sel_code),
        .sel_data(sel_data), .irq_req(irq_req), .ext_ovf(ext_ovf),
        .io_ovf(io_ovf), .mck_ovf(mck_ovf)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R11";

    // behavioural reference model
    bit [47:0] m_ext [$];
    bit [31:0] m_mck [$];
    bit [31:0] m_io [8][$];
    bit m_tod, m_cpt, m_eovf, m_iovf, m_movf;

    task automatic chk(string r, string what, logic [47:0] act, logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", r, what, act, exp, $time);
        end
    endtask

    function automatic void msel(output int c, output bit [15:0] cd,
                                 output bit [31:0] dt, output bit dr, output int is);
        c = 0; cd = 0; dt = 0; dr = 0; is = 0;
        if (exc_sync_valid) begin
            c = 1; cd = exc_sync_code;
        end else if (psw_mchk_en && m_mck.size() > 0) begin
            if (crw_enable) begin c = 2; dt = m_mck[$]; end
            else dr = 1;
        end else if (psw_ext_en && (m_ext.size() > 0 || m_tod || m_cpt)) begin
            c = 3;
            if (m_ext.size() > 0) begin cd = m_ext[$][47:32]; dt = m_ext[$][31:0]; end
            else if (m_tod) cd = 16'h1004;
            else cd = 16'h1005;
        end else if (psw_io_en) begin
            for (int i = 0; i < 8; i++)
                if (c == 0 && io_sub_mask[i] && m_io[i].size() > 0) begin
                    c = 4; cd = 16'(i); dt = m_io[i][$]; is = i;
                end
        end
    endfunction

    function automatic bit m_irq();
        bit any = m_tod | m_cpt | (m_ext.size() > 0) | (m_mck.size() > 0);
        for (int i = 0; i < 8; i++) any |= (m_io[i].size() > 0);
        return any;
    endfunction

    bit m_req = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            int c, is; bit [15:0] cd; bit [31:0] dt; bit dr;
            msel(c, cd, dt, dr, is);
            if (dr) void'(m_mck.pop_back());
            if (ack && c != 0) begin
                case (c)
                    2: void'(m_mck.pop_back());
                    3: if (m_ext.size() > 0) void'(m_ext.pop_back());
                       else if (m_tod) m_tod = 0;
                       else m_cpt = 0;
                    4: void'(m_io[is].pop_back());
                    default: ;
                endcase
            end
            if (ext_push) begin
                if (m_ext.size() == DEPTH) m_eovf = 1;
                else m_ext.push_back({ext_push_code, ext_push_param});
            end
            if (mck_push) begin
                if (m_mck.size() == DEPTH) m_movf = 1;
                else m_mck.push_back(mck_push_info);
            end
            if (io_push) begin
                if (m_io[io_push_sub].size() == DEPTH) m_iovf = 1;
                else m_io[io_push_sub].push_back(io_push_word);
            end
            if (tod_req) m_tod = 1;
            if (cpt_req) m_cpt = 1;
            m_req = m_irq();
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int c, is; bit [15:0] cd; bit [31:0] dt; bit dr;
            msel(c, cd, dt, dr, is);
            chk(cur_req, "sel_valid", 48'(sel_valid), 48'(c != 0));
            chk(cur_req, "sel_class", 48'(sel_class), 48'(c));
            chk(cur_req, "sel_code",  48'(sel_code),  48'(cd));
            chk(cur_req, "sel_data",  48'(sel_data),  48'(dt));
            chk(cur_req, "irq_req",   48'(irq_req),   48'(m_req));
            chk("R8", "ovf flags", 48'({ext_ovf, io_ovf, mck_ovf}), 48'({m_eovf, m_iovf, m_movf}));
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk); #2;
            ext_push = 0; io_push = 0; mck_push = 0; ack = 0; tod_req = 0; cpt_req = 0;
        end
    endtask

    task automatic push_ext(bit [15:0] c, bit [31:0] p);
        ext_push = 1; ext_push_code = c; ext_push_param = p; step();
    endtask

    task automatic push_io(bit [2:0] s, bit [31:0] w);
        io_push = 1; io_push_sub = s; io_push_word = w; step();
    endtask

    task automatic push_mck(bit [31:0] w);
        mck_push = 1; mck_push_info = w; step();
    endtask

    task automatic take();
        ack = 1; step();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "reset outputs", 48'({sel_valid, irq_req, ext_ovf, io_ovf, mck_ovf, sel_class}), 48'h0);
        @(posedge clk); #2;

        cur_req = "R1";
        push_ext(16'hABCD, 32'h11);
        push_io(3'd3, 32'h33);
        push_mck(32'hC0);
        step();
        psw_io_en = 1; io_sub_mask = 8'hFF; step();
        psw_ext_en = 1; step();
        psw_mchk_en = 1; crw_enable = 1; step();
        exc_sync_valid = 1; exc_sync_code = 16'h0004; step();
        take();
        exc_sync_valid = 0; step();

        cur_req = "R7";
        take();
        push_ext(16'h2001, 32'hA1);
        push_ext(16'h2002, 32'hA2);
        take();
        ext_push = 1; ext_push_code = 16'h2003; ext_push_param = 32'hA3; ack = 1; step();
        take(); take(); take();

        cur_req = "R2";
        tod_req = 1; cpt_req = 1; step();
        cur_req = "R3";
        take();
        tod_req = 1; ack = 1; step();
        take(); take();

        cur_req = "R4";
        push_io(3'd5, 32'h55);
        push_io(3'd2, 32'h22);
        step();
        io_sub_mask = 8'hFB; step();
        cur_req = "R5";
        io_sub_mask = 8'h80; ack = 1; step(); step();
        io_sub_mask = 8'h20; take();
        io_sub_mask = 8'hFF;

        cur_req = "R6";
        crw_enable = 0;
        push_mck(32'hD1);
        step(2);
        crw_enable = 1;

        cur_req = "R8";
        psw_ext_en = 0;
        for (int i = 0; i < 6; i++) push_ext(16'h3000 + 16'(i), 32'(i));
        push_mck(32'h1); push_mck(32'h2); push_mck(32'h3); push_mck(32'h4); push_mck(32'h5);

        cur_req = "R10";
        psw_mchk_en = 0; psw_io_en = 0;
        take(); step();
        psw_mchk_en = 1; psw_ext_en = 1; psw_io_en = 1;

        cur_req = "R1";
        for (int i = 0; i < 600; i++) begin
            bit [31:0] r = $urandom;
            ext_push = (r[2:0] == 0); ext_push_code = 16'(r[31:16]); ext_push_param = $urandom;
            io_push = (r[5:3] < 2); io_push_sub = r[8:6]; io_push_word = $urandom;
            mck_push = (r[11:9] == 0); mck_push_info = $urandom;
            tod_req = (r[15:12] == 0); cpt_req = (r[15:12] == 1);
            ack = r[17] | r[18];
            psw_mchk_en = r[19] | r[20]; psw_ext_en = r[21] | r[22]; psw_io_en = r[23] | r[24];
            crw_enable = r[25] | r[26] | r[27];
            exc_sync_valid = (r[30:28] == 0); exc_sync_code = 16'(r[15:0]);
            io_sub_mask = 8'($urandom) | 8'(r[31]);
            @(posedge clk); #2;
        end
        ext_push = 0; io_push = 0; mck_push = 0; tod_req = 0; cpt_req = 0; ack = 0;

        cur_req = "R9";
        exc_sync_valid = 0; psw_mchk_en = 1; psw_ext_en = 1; psw_io_en = 1;
        crw_enable = 1; io_sub_mask = 8'hFF;
        for (int i = 0; i < 200; i++) begin
            ack = 1; @(posedge clk); #2;
        end
        ack = 0;
        @(negedge clk);
        // R9 all drained, request low
        chk("R9", "irq_req after drain", 48'(irq_req), 48'h0);
        step();
        finish_run();
    end

endmodule